// File: doc/BRIEF.md
# Configuration-Space Base Register and Expansion-ROM Sizing Unit

This unit holds the configuration dwords of one bus function, including the six base-register slots and the expansion-ROM register. Host software probes the size of a window with an all-ones write and then programs a base. Each base slot is set at build time: whether it is present, whether it decodes memory or I/O, its power-of-two size and its reset contents. A memory window cannot be moved. Any ordinary write to it restores the reset contents. An I/O window takes the written base and announces the move, so that the port decoder outside this unit can follow it.

Writes come in three widths. The data is right-justified on `cfg_wr_data`, and the byte offset selects the lanes. Reads return a whole dword with no delay, chosen by a dword index. The relocation notice is a small state machine with two states. `ST_QUIET` is the idle state. `ST_ANNOUNCE` drives the strobe. The machine enters `ST_ANNOUNCE` on the clock edge that accepts an I/O base write, and stays there while such writes come on consecutive edges. It falls back to `ST_QUIET` after the first edge that carries no such write.

Top module: `cfgbar_top`

## Requirements
- R1: After reset, every present base slot reads its reset value, absent slots read 0, the ROM register at dword 12 reads ROM_BASE (or 0 when ROM_SIZE is 0), every other dword reads 0, and `reloc_strobe` is low.
- R2: A 32-bit write to a present memory slot (offsets 0x10..0x27, slot = (offset-0x10)>>2) whose data satisfies (data | 3 | (size-1)) == 0xFFFFFFFF stores ~(size-1), with bit 0 clear.
- R3: Any other 32-bit write to a present memory slot restores that slot's reset value, whatever the written data.
- R4: A 32-bit write to a present I/O slot stores data | 1. When the data is a probe (same test as R2), the slot stores ~(size-1) | 1 instead.
- R5: On the edge after an I/O slot write, `reloc_strobe` is high for one cycle. `reloc_bar` gives the slot number, and `reloc_old_base` and `reloc_new_base` give bits 15:0 of the old and new contents, each with bit 0 cleared. Writes to memory slots never raise the strobe.
- R6: A 32-bit write to an absent slot stores 0.
- R7: A 32-bit write to offset 0x30 stores 0 - ROM_SIZE when (data | 0x7FF) == 0xFFFFFFFF. Any other 32-bit write there stores ROM_BASE. With ROM_SIZE of 0, such a write stores 0.
- R8: 16-bit writes whose offset lies in 0x10..0x2B change nothing and raise no strobe. A 16-bit write at 0x2C is stored normally.
- R9: A 32-bit write to offset 0x04 changes nothing. 8- and 16-bit writes there are stored.
- R10: `cfg_wr_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = no write. An 8-bit write stores data[7:0] into byte offset[1:0]. A 16-bit write stores data[15:0] into half offset[1]. A 32-bit write to any offset not covered above stores the full word. 8-bit writes into the base window are stored like any other byte write.
- R11: `cfg_rd_data` shows dword `cfg_rd_dw` with no delay, and a write is visible in the cycle after the edge that accepts it.
- R12: I/O slot writes on consecutive edges produce a strobe in each following cycle, each with its own slot number and bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write request this cycle |
| cfg_wr_off | input | 8 | Byte offset of the write |
| cfg_wr_size | input | 2 | Access width code (R10) |
| cfg_wr_data | input | 32 | Right-justified write data |
| cfg_rd_dw | input | 6 | Dword index to read |
| cfg_rd_data | output | 32 | Read data |
| reloc_strobe | output | 1 | One-cycle I/O relocation notice |
| reloc_bar | output | 3 | Slot that moved |
| reloc_old_base | output | 16 | Previous I/O base, bit 0 clear |
| reloc_new_base | output | 16 | New I/O base, bit 0 clear |

## Verification
A slot register that holds the wrong value shows up on `cfg_rd_data` in the first cycle after the write, provided the read index points at that dword. The bench therefore moves the index to each written dword and compares it on every clock against a model of the whole space. A misclassified write has two visible effects. A memory slot that fails to snap back shows the written data. A 16-bit write inside the window that is not dropped shows a changed half-word. If the relocation machine is stuck or skips a cycle, the strobe and the two base buses are wrong one cycle after the I/O write. Back-to-back writes show whether the machine keeps `ST_ANNOUNCE` for the second write.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;

    localparam int OFF_W        = 8;
    localparam int CFG_DWORDS   = 2 ** (OFF_W - 2);
    localparam int DW_W         = OFF_W - 2;
    localparam int BAR_FIRST_DW = 4;
    localparam int BAR_COUNT    = 6;
    localparam int BAR_IDX_W    = 3;
    localparam int ROM_DW       = 12;
    localparam int HOLD_DW      = 1;
    localparam logic [OFF_W-1:0] NARROW_LO = 8'h10;
    localparam logic [OFF_W-1:0] NARROW_HI = 8'h2B;

    typedef enum logic [1:0] {
        ACC_B8  = 2'd0,
        ACC_B16 = 2'd1,
        ACC_B32 = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_LANES,
        WK_BAR,
        WK_ROM,
        WK_HOLD,
        WK_DROP
    } wr_kind_e;

    typedef enum logic {
        ST_QUIET,
        ST_ANNOUNCE
    } rel_state_e;

    function automatic bit size_ok(logic [31:0] s);
        return (s >= 32'd4) && ((s & (s - 32'd1)) == 32'd0);
    endfunction

    function automatic logic [31:0] merge_lanes(logic [31:0] cur, logic [31:0] nd,
                                                logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = be[i] ? nd[8*i +: 8] : cur[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgbar_decode.sv
module cfgbar_decode
    import cfgbar_pkg::*;
(
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       wr_off,
    input  acc_size_e              wr_size,
    input  logic [31:0]            wr_data,
    output wr_kind_e               kind,
    output logic [DW_W-1:0]        dw_idx,
    output logic [3:0]             be,
    output logic [31:0]            lane_data
);

    logic in_narrow_win;

    always_comb begin
        dw_idx        = wr_off[OFF_W-1:2];
        in_narrow_win = (wr_off >= NARROW_LO) && (wr_off <= NARROW_HI);
        kind          = WK_NONE;
        be            = 4'b0000;
        lane_data     = wr_data;
        if (wr_en) begin
            unique case (wr_size)
                ACC_B8: begin
                    kind      = WK_LANES;
                    be        = 4'b0001 << wr_off[1:0];
                    lane_data = {4{wr_data[7:0]}};
                end
                ACC_B16: begin
                    if (in_narrow_win) begin
                        kind = WK_DROP;
                    end else begin
                        kind      = WK_LANES;
                        be        = wr_off[1] ? 4'b1100 : 4'b0011;
                        lane_data = {2{wr_data[15:0]}};
                    end
                end
                ACC_B32: begin
                    if (int'(dw_idx) >= BAR_FIRST_DW &&
                        int'(dw_idx) <  BAR_FIRST_DW + BAR_COUNT) begin
                        kind = WK_BAR;
                    end else if (int'(dw_idx) == ROM_DW) begin
                        kind = WK_ROM;
                    end else if (int'(dw_idx) == HOLD_DW) begin
                        kind = WK_HOLD;
                    end else begin
                        kind = WK_LANES;
                        be   = 4'b1111;
                    end
                end
                default: kind = WK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cfgbar_plain_dword.sv
module cfgbar_plain_dword
    import cfgbar_pkg::*;
#(
    parameter logic [31:0] RESET_VAL = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lane_wr,
    input  logic [3:0]  be,
    input  logic [31:0] lane_data,
    output logic [31:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RESET_VAL;
        end else if (lane_wr) begin
            value <= merge_lanes(value, lane_data, be);
        end
    end

endmodule

// File: rtl/cfgbar_bar_slot.sv
module cfgbar_bar_slot
    import cfgbar_pkg::*;
#(
    parameter bit          SLOT_EN   = 1'b0,
    parameter bit          IS_IO     = 1'b0,
    parameter logic [31:0] SIZE      = 32'd16,
    parameter logic [31:0] RESET_VAL = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bar_wr,
    input  logic        lane_wr,
    input  logic [3:0]  be,
    input  logic [31:0] lane_data,
    input  logic [31:0] wr_data,
    output logic [31:0] value,
    output logic        reloc_fire,
    output logic [15:0] old_base,
    output logic [15:0] new_base
);

    localparam logic [31:0] SIZE_MASK = SIZE - 32'd1;
    localparam logic [31:0] SIZED_VAL = ~SIZE_MASK | {31'd0, IS_IO};
    localparam logic [31:0] BOOT_VAL  = SLOT_EN ? RESET_VAL : 32'd0;

    generate
        if (SLOT_EN && !size_ok(SIZE)) begin : g_bad_size
            $error("base slot size must be a power of two of at least 4");
        end
    endgenerate

    logic        probe;
    logic [31:0] bar_next;
    logic [31:0] value_next;

    always_comb begin
        probe = (wr_data | 32'h3 | SIZE_MASK) == 32'hFFFF_FFFF;
        if (!SLOT_EN) begin
            bar_next = 32'd0;
        end else if (IS_IO) begin
            bar_next = probe ? SIZED_VAL : (wr_data | 32'h1);
        end else begin
            bar_next = probe ? SIZED_VAL : RESET_VAL;
        end
        value_next = value;
        if (bar_wr) begin
            value_next = bar_next;
        end else if (lane_wr) begin
            value_next = merge_lanes(value, lane_data, be);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= BOOT_VAL;
        end else begin
            value <= value_next;
        end
    end

    assign reloc_fire = bar_wr && SLOT_EN && IS_IO;
    assign old_base   = value[15:0] & 16'hFFFE;
    assign new_base   = bar_next[15:0] & 16'hFFFE;

endmodule

// File: rtl/cfgbar_rom_slot.sv
module cfgbar_rom_slot
    import cfgbar_pkg::*;
#(
    parameter logic [31:0] ROM_SIZE = 32'd0,
    parameter logic [31:0] ROM_BASE = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rom_wr,
    input  logic        lane_wr,
    input  logic [3:0]  be,
    input  logic [31:0] lane_data,
    input  logic [31:0] wr_data,
    output logic [31:0] value
);

    localparam bit          HAS_ROM   = (ROM_SIZE != 32'd0);
    localparam logic [31:0] BOOT_VAL  = HAS_ROM ? ROM_BASE : 32'd0;
    localparam logic [31:0] SIZED_VAL = 32'd0 - ROM_SIZE;

    generate
        if (HAS_ROM && !(size_ok(ROM_SIZE) && ROM_SIZE >= 32'd2048)) begin : g_bad_rom
            $error("ROM size must be a power of two of at least 2048");
        end
    endgenerate

    logic [31:0] rom_next;

    always_comb begin
        if (!HAS_ROM) begin
            rom_next = 32'd0;
        end else if ((wr_data | 32'h7FF) == 32'hFFFF_FFFF) begin
            rom_next = SIZED_VAL;
        end else begin
            rom_next = ROM_BASE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= BOOT_VAL;
        end else if (rom_wr) begin
            value <= rom_next;
        end else if (lane_wr) begin
            value <= merge_lanes(value, lane_data, be);
        end
    end

endmodule

// File: rtl/cfgbar_top.sv
module cfgbar_top
    import cfgbar_pkg::*;
#(
    parameter logic [5:0]       BAR_EN    = 6'b011011,
    parameter logic [5:0]       BAR_IS_IO = 6'b010010,
    parameter logic [5:0][31:0] BAR_SIZE  = {32'h10, 32'h100, 32'h0010_0000,
                                             32'h10, 32'h20,  32'h1000},
    parameter logic [5:0][31:0] BAR_RESET = {32'h0, 32'h0000_D001, 32'hF000_0008,
                                             32'h0, 32'h0000_C001, 32'hFEB0_0000},
    parameter logic [31:0]      ROM_SIZE  = 32'h0001_0000,
    parameter logic [31:0]      ROM_BASE  = 32'hFEC0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_wr_off,
    input  logic [1:0]  cfg_wr_size,
    input  logic [31:0] cfg_wr_data,
    input  logic [5:0]  cfg_rd_dw,
    output logic [31:0] cfg_rd_data,
    output logic        reloc_strobe,
    output logic [2:0]  reloc_bar,
    output logic [15:0] reloc_old_base,
    output logic [15:0] reloc_new_base
);

    wr_kind_e          kind;
    logic [DW_W-1:0]   dw_idx;
    logic [3:0]        be;
    logic [31:0]       lane_data;
    logic [31:0]       regs [CFG_DWORDS];
    logic [BAR_COUNT-1:0] fire;
    logic [15:0]       old_arr [BAR_COUNT];
    logic [15:0]       new_arr [BAR_COUNT];

    cfgbar_decode u_decode (
        .wr_en     (cfg_wr_en),
        .wr_off    (cfg_wr_off),
        .wr_size   (acc_size_e'(cfg_wr_size)),
        .wr_data   (cfg_wr_data),
        .kind      (kind),
        .dw_idx    (dw_idx),
        .be        (be),
        .lane_data (lane_data)
    );

    for (genvar g = 0; g < CFG_DWORDS; g++) begin : g_dw
        logic hit_lane;
        assign hit_lane = (kind == WK_LANES) && (int'(dw_idx) == g);
        if (g >= BAR_FIRST_DW && g < BAR_FIRST_DW + BAR_COUNT) begin : g_bar
            localparam int B = g - BAR_FIRST_DW;
            cfgbar_bar_slot #(
                .SLOT_EN   (BAR_EN[B]),
                .IS_IO     (BAR_IS_IO[B]),
                .SIZE      (BAR_SIZE[B]),
                .RESET_VAL (BAR_RESET[B])
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .bar_wr     ((kind == WK_BAR) && (int'(dw_idx) == g)),
                .lane_wr    (hit_lane),
                .be         (be),
                .lane_data  (lane_data),
                .wr_data    (cfg_wr_data),
                .value      (regs[g]),
                .reloc_fire (fire[B]),
                .old_base   (old_arr[B]),
                .new_base   (new_arr[B])
            );
        end else if (g == ROM_DW) begin : g_rom
            cfgbar_rom_slot #(
                .ROM_SIZE (ROM_SIZE),
                .ROM_BASE (ROM_BASE)
            ) u_rom (
                .clk       (clk),
                .rst_n     (rst_n),
                .rom_wr    (kind == WK_ROM),
                .lane_wr   (hit_lane),
                .be        (be),
                .lane_data (lane_data),
                .wr_data   (cfg_wr_data),
                .value     (regs[g])
            );
        end else begin : g_plain
            cfgbar_plain_dword #(
                .RESET_VAL (32'd0)
            ) u_dw (
                .clk       (clk),
                .rst_n     (rst_n),
                .lane_wr   (hit_lane),
                .be        (be),
                .lane_data (lane_data),
                .value     (regs[g])
            );
        end
    end

    assign cfg_rd_data = regs[cfg_rd_dw];

    // Relocation announcement machine
    rel_state_e           state, state_next;
    logic                 any_fire;
    logic [BAR_IDX_W-1:0] sel_bar;
    logic [15:0]          sel_old, sel_new;

    always_comb begin
        any_fire = |fire;
        sel_bar  = '0;
        sel_old  = '0;
        sel_new  = '0;
        for (int b = 0; b < BAR_COUNT; b++) begin
            if (fire[b]) begin
                sel_bar = BAR_IDX_W'(b);
                sel_old = old_arr[b];
                sel_new = new_arr[b];
            end
        end
    end

    always_comb begin
        state_next = state;
        unique case (state)
            ST_QUIET:    state_next = any_fire ? ST_ANNOUNCE : ST_QUIET;
            ST_ANNOUNCE: state_next = any_fire ? ST_ANNOUNCE : ST_QUIET;
            default:     state_next = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_QUIET;
        end else begin
            state <= state_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reloc_bar      <= '0;
            reloc_old_base <= '0;
            reloc_new_base <= '0;
        end else if (any_fire) begin
            reloc_bar      <= sel_bar;
            reloc_old_base <= sel_old;
            reloc_new_base <= sel_new;
        end
    end

    assign reloc_strobe = (state == ST_ANNOUNCE);

endmodule

// File: rtl/cfgbar_chk.sv
module cfgbar_chk #(
    parameter logic [5:0] BAR_EN    = 6'b0,
    parameter logic [5:0] BAR_IS_IO = 6'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [7:0]  cfg_wr_off,
    input logic [1:0]  cfg_wr_size,
    input logic        reloc_strobe,
    input logic [2:0]  reloc_bar,
    input logic [15:0] reloc_old_base,
    input logic [15:0] reloc_new_base
);

    logic [5:0] dw;
    logic [2:0] slot;
    logic       in_win;
    logic       io_hit;
    logic       narrow_hit;
    logic       hold_hit;

    always_comb begin
        dw         = cfg_wr_off[7:2];
        slot       = 3'(dw - 6'd4);
        in_win     = (dw >= 6'd4) && (dw <= 6'd9);
        io_hit     = cfg_wr_en && (cfg_wr_size == 2'd2) && in_win &&
                     BAR_EN[slot] && BAR_IS_IO[slot];
        narrow_hit = cfg_wr_en && (cfg_wr_size == 2'd1) &&
                     (cfg_wr_off >= 8'h10) && (cfg_wr_off <= 8'h2B);
        hold_hit   = cfg_wr_en && (cfg_wr_size == 2'd2) && (dw == 6'd1);
    end

    AST_IO_WRITE_ANNOUNCES: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |=> (reloc_strobe && reloc_bar == $past(slot))); // R5

    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_strobe |-> $past(io_hit)); // R5

    AST_STROBE_IO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_strobe |-> (reloc_bar < 3'd6 && BAR_IS_IO[reloc_bar] && BAR_EN[reloc_bar])); // R5

    AST_BASE_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_strobe |-> (!reloc_old_base[0] && !reloc_new_base[0])); // R5

    AST_NARROW_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_hit |=> !reloc_strobe); // R8

    AST_HOLD_OFFSET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_hit |=> !reloc_strobe); // R9

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_hit && $past(io_hit)) |=> (reloc_strobe && $past(reloc_strobe, 1) == 1'b1)); // R12

endmodule

bind cfgbar_top cfgbar_chk #(
    .BAR_EN    (BAR_EN),
    .BAR_IS_IO (BAR_IS_IO)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_off     (cfg_wr_off),
    .cfg_wr_size    (cfg_wr_size),
    .reloc_strobe   (reloc_strobe),
    .reloc_bar      (reloc_bar),
    .reloc_old_base (reloc_old_base),
    .reloc_new_base (reloc_new_base)
);

// File: tb/cfgbar_top_tb_top.sv
module cfgbar_top_tb_top;

    localparam logic [5:0] T_EN = 6'b011011;
    localparam logic [5:0] T_IO = 6'b010010;
    localparam logic [31:0] T_SIZE [6] = '{32'h1000, 32'h20, 32'h10,
                                           32'h0010_0000, 32'h100, 32'h10};
    localparam logic [31:0] T_RST  [6] = '{32'hFEB0_0000, 32'h0000_C001, 32'h0,
                                           32'hF000_0008, 32'h0000_D001, 32'h0};
    localparam logic [31:0] T_ROMSZ = 32'h0001_0000;
    localparam logic [31:0] T_ROMBA = 32'hFEC0_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [7:0]  cfg_wr_off;
    logic [1:0]  cfg_wr_size;
    logic [31:0] cfg_wr_data;
    logic [5:0]  cfg_rd_dw;
    logic [31:0] cfg_rd_data;
    logic        reloc_strobe;
    logic [2:0]  reloc_bar;
    logic [15:0] reloc_old_base;
    logic [15:0] reloc_new_base;

    always #5 clk = ~clk;

    cfgbar_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_off     (cfg_wr_off),
        .cfg_wr_size    (cfg_wr_size),
        .cfg_wr_data    (cfg_wr_data),
        .cfg_rd_dw      (cfg_rd_dw),
        .cfg_rd_data    (cfg_rd_data),
        .reloc_strobe   (reloc_strobe),
        .reloc_bar      (reloc_bar),
        .reloc_old_base (reloc_old_base),
        .reloc_new_base (reloc_new_base)
    );

    int compared   = 0;
    int mismatched = 0;
    bit run        = 1'b0;
    bit done       = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    logic [31:0] m [64];
    bit          exp_strobe;
    int          exp_bar;
    logic [15:0] exp_old, exp_new;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 64; i++) m[i] = 32'd0;
        for (int b = 0; b < 6; b++) m[4 + b] = T_EN[b] ? T_RST[b] : 32'd0;
        m[12] = T_ROMSZ != 0 ? T_ROMBA : 32'd0;
        exp_strobe = 1'b0;
        exp_bar = 0;
        exp_old = 16'd0;
        exp_new = 16'd0;
    endfunction

    function automatic void model_write(int off, int sz, logic [31:0] d);
        int dw;
        logic [31:0] mk, nv;
        bit probe;
        dw = off / 4;
        if (sz == 0) begin
            m[dw][8*(off % 4) +: 8] = d[7:0];
        end else if (sz == 1) begin
            if (!(off >= 16 && off <= 43)) m[dw][16*((off / 2) % 2) +: 16] = d[15:0];
        end else if (sz == 2) begin
            if (dw >= 4 && dw <= 9) begin
                int b = dw - 4;
                if (!T_EN[b]) begin
                    m[dw] = 32'd0;
                end else begin
                    mk = T_SIZE[b] - 1;
                    probe = ((d | 32'h3 | mk) == 32'hFFFF_FFFF);
                    if (T_IO[b]) begin
                        nv = probe ? (~mk | 32'h1) : (d | 32'h1);
                        exp_strobe = 1'b1;
                        exp_bar = b;
                        exp_old = m[dw][15:0] & 16'hFFFE;
                        exp_new = nv[15:0] & 16'hFFFE;
                        m[dw] = nv;
                    end else begin
                        m[dw] = probe ? ~mk : T_RST[b];
                    end
                end
            end else if (dw == 12) begin
                if (T_ROMSZ == 0) m[dw] = 32'd0;
                else m[dw] = ((d | 32'h7FF) == 32'hFFFF_FFFF) ? (32'd0 - T_ROMSZ) : T_ROMBA;
            end else if (dw != 1) begin
                m[dw] = d;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            exp_strobe = 1'b0;
            if (cfg_wr_en) model_write(int'(cfg_wr_off), int'(cfg_wr_size), cfg_wr_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n && run) begin
            check(cur_req, "rd_data", cfg_rd_data, m[cfg_rd_dw]);
            check("R5", "strobe", {31'd0, reloc_strobe}, {31'd0, exp_strobe});
            if (exp_strobe) begin
                check("R5", "bar", {29'd0, reloc_bar}, 32'(exp_bar));
                check("R5", "old", {16'd0, reloc_old_base}, {16'd0, exp_old});
                check("R5", "new", {16'd0, reloc_new_base}, {16'd0, exp_new});
            end
        end
    end

    task automatic drive(logic [7:0] off, logic [1:0] sz, logic [31:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_off  = off;
        cfg_wr_size = sz;
        cfg_wr_data = d;
        cfg_rd_dw   = off[7:2];
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cfg_wr_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] off, logic [1:0] sz, logic [31:0] d);
        drive(off, sz, d);
        idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_off = '0; cfg_wr_size = '0;
        cfg_wr_data = '0; cfg_rd_dw = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; run = 1'b1;

        cur_req = "R1";                       // reset contents, R11 read path
        for (int i = 0; i < 64; i++) begin
            cfg_rd_dw = 6'(i);
            @(posedge clk); #1;
        end

        cur_req = "R10";
        wr(8'h00, 2'd2, 32'hA5A5_5A5A);
        wr(8'h3C, 2'd2, 32'h1122_3344);
        wr(8'h3D, 2'd0, 32'h0000_00EE);
        wr(8'h3E, 2'd1, 32'h0000_BEEF);
        wr(8'h11, 2'd0, 32'h0000_0077);       // byte into base window
        wr(8'h40, 2'd3, 32'hFFFF_FFFF);       // code 3: nothing

        cur_req = "R9";
        wr(8'h04, 2'd2, 32'hFFFF_FFFF);
        wr(8'h06, 2'd1, 32'h0000_0147);

        cur_req = "R2";
        wr(8'h10, 2'd2, 32'hFFFF_FFFF);
        wr(8'h10, 2'd2, 32'hFFFF_F000);
        wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
        cur_req = "R3";
        wr(8'h10, 2'd2, 32'h1234_5000);
        wr(8'h1C, 2'd2, 32'hE000_0000);

        cur_req = "R4";
        wr(8'h14, 2'd2, 32'h0000_B000);       // R5 old C000 new B000
        wr(8'h14, 2'd2, 32'hFFFF_FFFF);       // probe
        wr(8'h20, 2'd2, 32'h0000_E100);

        cur_req = "R12";
        drive(8'h20, 2'd2, 32'h0000_A200);
        drive(8'h14, 2'd2, 32'h0000_9000);
        idle();
        idle();

        cur_req = "R6";
        wr(8'h18, 2'd0, 32'h0000_0055);
        wr(8'h18, 2'd2, 32'hDEAD_BEEF);
        wr(8'h24, 2'd2, 32'hFFFF_FFFF);

        cur_req = "R7";
        wr(8'h30, 2'd2, 32'hFFFF_F800);
        wr(8'h30, 2'd2, 32'h1234_5678);
        wr(8'h30, 2'd2, 32'hFFFF_FFFF);
        wr(8'h30, 2'd2, 32'hFFFF_F000);

        cur_req = "R8";
        wr(8'h14, 2'd1, 32'h0000_1234);
        wr(8'h2A, 2'd1, 32'h0000_5678);
        wr(8'h2C, 2'd1, 32'h0000_CAFE);
        wr(8'h12, 2'd1, 32'h0000_FFFF);

        cur_req = "R11";
        for (int i = 0; i < 16; i++) begin
            cfg_rd_dw = 6'(i);
            @(posedge clk); #1;
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule